// File: doc/BRIEF.md
# Interrupt Steering Unit

This block decides where each interrupt request of a bridge chip lands. Four PCI interrupt inputs, the primary and secondary disk-controller interrupts, four legacy peripheral interrupts (parallel port, floppy, two serial ports) and a parameterised set of onboard-function interrupts are each steered by a small field in a byte-wide configuration register file. The outputs are a 16-line bus toward a legacy interrupt controller and a 24-line bus toward an APIC. Every output line is the wired-OR of all active-high sources currently steered onto it.

Software programs the routing with single-byte writes: an address, a data byte and a write strobe. Reads are combinational and return the stored field bits, with unused bits as zero. A routing nibble of zero turns a source off. Three nibble values are illegal for the PCI inputs: they are stored but drive nothing. One steering byte moves the onboard functions and the PCI inputs as a group from the legacy bus to the APIC bus. A source on the APIC bus never drives a legacy line.

Top module: `irq_route_top`

## Requirements
- R1: After reset every register reads 0x00, except the read-only pin registers. The PCI, peripheral and onboard sources are disabled, so with only those inputs high both output buses are zero. The disk-controller codes reset to 00.
- R2: Readback masks: 0x4A keeps bits 3:0; 0x51 and 0x56 keep all bits; 0x52, 0x55 and 0x57 keep bits 7:4; 0x53 keeps bits 3:0; 0x58 keeps bit 7 and bits 4:0. Every other bit reads as 0.
- R3: Register 0x4A steers the disk controllers. Bits 1:0 apply to the primary and bits 3:2 to the secondary. Code 00 selects legacy line 14, 01 line 15, 10 line 10 and 11 line 11.
- R4: Each PCI input is routed by a nibble: input A by 0x55[7:4], B by 0x56[3:0], C by 0x56[7:4] and D by 0x57[7:4]. A nonzero value n drives legacy line n, and 0 turns the input off.
- R5: A PCI routing nibble of 2, 8 or 13 reads back as written, but the input drives no line on either bus.
- R6: Parallel port is routed by 0x51[7:4], floppy by 0x51[3:0], serial 2 by 0x52[7:4] and serial 1 by 0x53[3:0]. A value n drives legacy line n, 0 turns the source off, and every value from 1 to 15 is allowed.
- R7: The onboard function k (0 = USB port 0, 1 = USB port 1, 2 = audio, 3 = modem, 4 = power management) has a line register at 0x60+k. It keeps only the low 4 bits of a write and routes like R6. Its pin register at 0x68+k is read-only and reads 4, 4, 3, 3, 1 for k = 0..4. Writes to a pin register do not change it.
- R8: Bit k of 0x58 moves onboard function k to APIC line 16 plus the low 3 bits of its line register, and its legacy line stays low. A line value of 0 still turns it off.
- R9: Bit 7 of 0x58 moves PCI inputs A to D to APIC lines 16 to 19 and keeps them off the legacy bus. The R4 and R5 enable rules still apply. APIC lines 0 to 15 are never driven.
- R10: Sources steered to the same output line share it as a logical OR of their levels.
- R11: Reads of any unmapped address return 0x00. Writes to one leave every mapped register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for one byte |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| pci_int | input | 4 | PCI interrupt inputs A..D, active high |
| ide_pri_irq | input | 1 | Primary disk-controller interrupt |
| ide_sec_irq | input | 1 | Secondary disk-controller interrupt |
| par_irq | input | 1 | Parallel-port interrupt |
| fdc_irq | input | 1 | Floppy interrupt |
| ser1_irq | input | 1 | Serial port 1 interrupt |
| ser2_irq | input | 1 | Serial port 2 interrupt |
| onb_irq | input | NUM_ONB | Onboard function interrupts |
| leg_irq | output | 16 | Legacy controller request lines |
| apic_irq | output | 24 | APIC request lines |

## Verification
The bench builds the block with its defaults: five onboard functions, 16 legacy lines, 24 APIC lines and an APIC base of 16. With five functions, all five steering bits of 0x58 and all five line and pin register pairs are present. A 24-line APIC bus makes the highest remapped lines (22 and 23) reachable from a line value of 14 or 15. The onboard count stays below seven, so bit 7 of the steering byte stays free for the PCI group.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

  localparam int NUM_PCI = 4;
  localparam int NUM_DEV = 4;

  localparam logic [7:0] A_IDE      = 8'h4A;
  localparam logic [7:0] A_LPT_FDC  = 8'h51;
  localparam logic [7:0] A_SER2     = 8'h52;
  localparam logic [7:0] A_SER1     = 8'h53;
  localparam logic [7:0] A_PIRQ_A   = 8'h55;
  localparam logic [7:0] A_PIRQ_BC  = 8'h56;
  localparam logic [7:0] A_PIRQ_D   = 8'h57;
  localparam logic [7:0] A_STEER    = 8'h58;
  localparam logic [7:0] A_ONB_LINE = 8'h60;
  localparam logic [7:0] A_ONB_PIN  = 8'h68;

  // Disk controller 2-bit code to legacy line number.
  function automatic logic [3:0] ide_line(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd14;
      2'b01:   return 4'd15;
      2'b10:   return 4'd10;
      default: return 4'd11;
    endcase
  endfunction

  // Hard-wired interrupt pin of onboard function k.
  function automatic logic [7:0] onb_pin(input int k);
    case (k)
      0, 1:    return 8'd4;
      2, 3:    return 8'd3;
      default: return 8'd1;
    endcase
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_ONB = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [7:0]                    addr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rdata,
  output logic [1:0]                    ide_pri_code,
  output logic [1:0]                    ide_sec_code,
  output logic [NUM_PCI-1:0][3:0]       pirq_route,
  output logic [NUM_DEV-1:0][3:0]       dev_route,
  output logic [NUM_ONB-1:0][3:0]       onb_route,
  output logic [NUM_ONB-1:0]            onb_apic,
  output logic                          pci_apic
);

  logic [3:0]               ide_q, ide_d;
  logic [7:0]               r51_q, r51_d;
  logic [3:0]               r52_q, r52_d;
  logic [3:0]               r53_q, r53_d;
  logic [3:0]               r55_q, r55_d;
  logic [7:0]               r56_q, r56_d;
  logic [3:0]               r57_q, r57_d;
  logic                     pci_apic_q, pci_apic_d;
  logic [NUM_ONB-1:0]       onb_apic_q, onb_apic_d;
  logic [NUM_ONB-1:0][3:0]  onb_q, onb_d;

  // Next-state decode of a write.
  always_comb begin
    ide_d      = ide_q;
    r51_d      = r51_q;
    r52_d      = r52_q;
    r53_d      = r53_q;
    r55_d      = r55_q;
    r56_d      = r56_q;
    r57_d      = r57_q;
    pci_apic_d = pci_apic_q;
    onb_apic_d = onb_apic_q;
    onb_d      = onb_q;
    case (addr)
      A_IDE:     ide_d = wdata[3:0];
      A_LPT_FDC: r51_d = wdata;
      A_SER2:    r52_d = wdata[7:4];
      A_SER1:    r53_d = wdata[3:0];
      A_PIRQ_A:  r55_d = wdata[7:4];
      A_PIRQ_BC: r56_d = wdata;
      A_PIRQ_D:  r57_d = wdata[7:4];
      A_STEER: begin
        pci_apic_d = wdata[7];
        onb_apic_d = wdata[NUM_ONB-1:0];
      end
      default: ;
    endcase
    for (int k = 0; k < NUM_ONB; k++) begin
      if (addr == A_ONB_LINE + 8'(k)) onb_d[k] = wdata[3:0];
    end
  end

  // State, loaded only when the strobe is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ide_q      <= '0;
      r51_q      <= '0;
      r52_q      <= '0;
      r53_q      <= '0;
      r55_q      <= '0;
      r56_q      <= '0;
      r57_q      <= '0;
      pci_apic_q <= 1'b0;
      onb_apic_q <= '0;
      onb_q      <= '0;
    end else if (we) begin
      ide_q      <= ide_d;
      r51_q      <= r51_d;
      r52_q      <= r52_d;
      r53_q      <= r53_d;
      r55_q      <= r55_d;
      r56_q      <= r56_d;
      r57_q      <= r57_d;
      pci_apic_q <= pci_apic_d;
      onb_apic_q <= onb_apic_d;
      onb_q      <= onb_d;
    end
  end

  // Readback, unused bits zero.
  always_comb begin
    rdata = '0;
    case (addr)
      A_IDE:     rdata = {4'b0, ide_q};
      A_LPT_FDC: rdata = r51_q;
      A_SER2:    rdata = {r52_q, 4'b0};
      A_SER1:    rdata = {4'b0, r53_q};
      A_PIRQ_A:  rdata = {r55_q, 4'b0};
      A_PIRQ_BC: rdata = r56_q;
      A_PIRQ_D:  rdata = {r57_q, 4'b0};
      A_STEER: begin
        rdata[7]           = pci_apic_q;
        rdata[NUM_ONB-1:0] = onb_apic_q;
      end
      default: ;
    endcase
    for (int k = 0; k < NUM_ONB; k++) begin
      if (addr == A_ONB_LINE + 8'(k)) rdata = {4'b0, onb_q[k]};
      if (addr == A_ONB_PIN + 8'(k))  rdata = onb_pin(k);
    end
  end

  assign ide_pri_code  = ide_q[1:0];
  assign ide_sec_code  = ide_q[3:2];
  assign pirq_route[0] = r55_q;
  assign pirq_route[1] = r56_q[3:0];
  assign pirq_route[2] = r56_q[7:4];
  assign pirq_route[3] = r57_q;
  assign dev_route[0]  = r51_q[7:4];
  assign dev_route[1]  = r51_q[3:0];
  assign dev_route[2]  = r52_q;
  assign dev_route[3]  = r53_q;
  assign onb_route     = onb_q;
  assign onb_apic      = onb_apic_q;
  assign pci_apic      = pci_apic_q;

  AST_PIRQA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_PIRQ_A) |=> (pirq_route[0] == $past(wdata[7:4]))); // R4

  AST_IDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_IDE) |=> ({ide_sec_code, ide_pri_code} == $past(wdata[3:0]))); // R3

  AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(pirq_route) && $stable(onb_route) && $stable(onb_apic)); // R11

endmodule

// File: rtl/irq_route_lane.sv
`timescale 1ns/1ps
module irq_route_lane #(
  parameter int LEG_LINES  = 16,
  parameter int APIC_LINES = 24,
  parameter bit FORBID     = 1'b0,
  localparam int AIW       = $clog2(APIC_LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  src,
  input  logic [3:0]            route,
  input  logic                  to_apic,
  input  logic [AIW-1:0]        apic_idx,
  output logic [LEG_LINES-1:0]  leg_vec,
  output logic [APIC_LINES-1:0] apic_vec
);

  logic illegal;
  logic allowed;

  assign illegal = FORBID && (route == 4'd2 || route == 4'd8 || route == 4'd13);
  assign allowed = (route != 4'd0) && !illegal;

  always_comb begin
    leg_vec  = '0;
    apic_vec = '0;
    if (src && allowed) begin
      if (to_apic) apic_vec[apic_idx] = 1'b1;
      else         leg_vec[route]     = 1'b1;
    end
  end

  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (route == 4'd0) |-> (leg_vec == '0 && apic_vec == '0)); // R4

  AST_APIC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    to_apic |-> (leg_vec == '0)); // R8

  AST_ONE_HOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({leg_vec, apic_vec})); // R10

  if (FORBID) begin : g_forbid
    AST_FORBID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (route == 4'd2 || route == 4'd8 || route == 4'd13)
        |-> (leg_vec == '0 && apic_vec == '0)); // R5
  end

endmodule

// File: rtl/irq_route_top.sv
`timescale 1ns/1ps
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_ONB    = 5,
  parameter int LEG_LINES  = 16,
  parameter int APIC_LINES = 24,
  parameter int APIC_BASE  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  input  logic [NUM_PCI-1:0]    pci_int,
  input  logic                  ide_pri_irq,
  input  logic                  ide_sec_irq,
  input  logic                  par_irq,
  input  logic                  fdc_irq,
  input  logic                  ser1_irq,
  input  logic                  ser2_irq,
  input  logic [NUM_ONB-1:0]    onb_irq,
  output logic [LEG_LINES-1:0]  leg_irq,
  output logic [APIC_LINES-1:0] apic_irq
);

  localparam int AIW      = $clog2(APIC_LINES);
  localparam int IDE_BASE = NUM_PCI;
  localparam int DEV_BASE = IDE_BASE + 2;
  localparam int ONB_BASE = DEV_BASE + NUM_DEV;
  localparam int NUM_SRC  = ONB_BASE + NUM_ONB;

  // Reset: asserted at once, released on the clock.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [1:0]               ide_pri_code, ide_sec_code;
  logic [NUM_PCI-1:0][3:0]  pirq_route;
  logic [NUM_DEV-1:0][3:0]  dev_route;
  logic [NUM_ONB-1:0][3:0]  onb_route;
  logic [NUM_ONB-1:0]       onb_apic;
  logic                     pci_apic;

  irq_route_regs #(.NUM_ONB(NUM_ONB)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .ide_pri_code(ide_pri_code), .ide_sec_code(ide_sec_code),
    .pirq_route(pirq_route), .dev_route(dev_route),
    .onb_route(onb_route), .onb_apic(onb_apic), .pci_apic(pci_apic)
  );

  // Per-source lane inputs.
  logic [NUM_SRC-1:0]           src;
  logic [NUM_SRC-1:0][3:0]      route;
  logic [NUM_SRC-1:0]           to_apic;
  logic [NUM_SRC-1:0][AIW-1:0]  apic_idx;

  always_comb begin
    src      = '0;
    route    = '0;
    to_apic  = '0;
    apic_idx = '0;
    for (int i = 0; i < NUM_PCI; i++) begin
      src[i]      = pci_int[i];
      route[i]    = pirq_route[i];
      to_apic[i]  = pci_apic;
      apic_idx[i] = AIW'(APIC_BASE + i);
    end
    src[IDE_BASE]       = ide_pri_irq;
    route[IDE_BASE]     = ide_line(ide_pri_code);
    src[IDE_BASE+1]     = ide_sec_irq;
    route[IDE_BASE+1]   = ide_line(ide_sec_code);
    src[DEV_BASE+0]     = par_irq;
    src[DEV_BASE+1]     = fdc_irq;
    src[DEV_BASE+2]     = ser2_irq;
    src[DEV_BASE+3]     = ser1_irq;
    for (int i = 0; i < NUM_DEV; i++) route[DEV_BASE+i] = dev_route[i];
    for (int k = 0; k < NUM_ONB; k++) begin
      src[ONB_BASE+k]      = onb_irq[k];
      route[ONB_BASE+k]    = onb_route[k];
      to_apic[ONB_BASE+k]  = onb_apic[k];
      apic_idx[ONB_BASE+k] = AIW'(APIC_BASE) + AIW'(onb_route[k][2:0]);
    end
  end

  logic [NUM_SRC-1:0][LEG_LINES-1:0]  leg_vec;
  logic [NUM_SRC-1:0][APIC_LINES-1:0] apic_vec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
    irq_route_lane #(
      .LEG_LINES(LEG_LINES), .APIC_LINES(APIC_LINES), .FORBID(g < NUM_PCI)
    ) u_lane (
      .clk(clk), .rst_n(rst_sync_n),
      .src(src[g]), .route(route[g]), .to_apic(to_apic[g]),
      .apic_idx(apic_idx[g]),
      .leg_vec(leg_vec[g]), .apic_vec(apic_vec[g])
    );
  end

  // Shared lines: OR of every lane.
  always_comb begin
    leg_irq  = '0;
    apic_irq = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      leg_irq  = leg_irq  | leg_vec[i];
      apic_irq = apic_irq | apic_vec[i];
    end
  end

  AST_APIC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    apic_irq[APIC_BASE-1:0] == '0); // R9

  AST_LEG_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !leg_irq[0]); // R4

endmodule

// File: tb/sim_irq_route_top.sv
`timescale 1ns/1ps
module sim_irq_route_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
  logic [3:0]  pci_int;
  logic        ide_pri_irq, ide_sec_irq, par_irq, fdc_irq, ser1_irq, ser2_irq;
  logic [4:0]  onb_irq;
  logic [15:0] leg_irq;
  logic [23:0] apic_irq;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  irq_route_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pci_int(pci_int),
    .ide_pri_irq(ide_pri_irq), .ide_sec_irq(ide_sec_irq), .par_irq(par_irq),
    .fdc_irq(fdc_irq), .ser1_irq(ser1_irq), .ser2_irq(ser2_irq),
    .onb_irq(onb_irq), .leg_irq(leg_irq), .apic_irq(apic_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(tag, {24'b0, cfg_rdata}, {24'b0, exp});
  endtask

  task automatic idle_src();
    pci_int = '0; ide_pri_irq = 0; ide_sec_irq = 0; par_irq = 0;
    fdc_irq = 0; ser1_irq = 0; ser2_irq = 0; onb_irq = '0;
  endtask

  task automatic out_chk(input string tag, input logic [15:0] le, input logic [23:0] ae);
    #1;
    chk({tag, " legacy"}, {16'b0, leg_irq}, {16'b0, le});
    chk({tag, " apic"}, {8'b0, apic_irq}, {8'b0, ae});
  endtask

  task automatic t_reset();
    rd_chk("R1 0x4A", 8'h4A, 8'h00);
    rd_chk("R1 0x55", 8'h55, 8'h00);
    rd_chk("R1 0x56", 8'h56, 8'h00);
    rd_chk("R1 0x58", 8'h58, 8'h00);
    rd_chk("R1 0x60", 8'h60, 8'h00);
    pci_int = 4'hF; par_irq = 1; fdc_irq = 1; ser1_irq = 1; ser2_irq = 1; onb_irq = '1;
    out_chk("R1 sources off", 16'h0, 24'h0);
    idle_src();
    ide_pri_irq = 1;
    out_chk("R1 disk default line 14", 16'h4000, 24'h0);
    idle_src();
  endtask

  task automatic t_readback();
    wr(8'h4A, 8'hFF); rd_chk("R2 0x4A mask", 8'h4A, 8'h0F);
    wr(8'h51, 8'hFF); rd_chk("R2 0x51 mask", 8'h51, 8'hFF);
    wr(8'h52, 8'hFF); rd_chk("R2 0x52 mask", 8'h52, 8'hF0);
    wr(8'h53, 8'hFF); rd_chk("R2 0x53 mask", 8'h53, 8'h0F);
    wr(8'h55, 8'hFF); rd_chk("R2 0x55 mask", 8'h55, 8'hF0);
    wr(8'h56, 8'hFF); rd_chk("R2 0x56 mask", 8'h56, 8'hFF);
    wr(8'h57, 8'hFF); rd_chk("R2 0x57 mask", 8'h57, 8'hF0);
    wr(8'h58, 8'hFF); rd_chk("R2 0x58 mask", 8'h58, 8'h9F);
    foreach (addrs_clr[i]) wr(addrs_clr[i], 8'h00);
  endtask

  logic [7:0] addrs_clr [8] = '{8'h4A, 8'h51, 8'h52, 8'h53, 8'h55, 8'h56, 8'h57, 8'h58};

  task automatic t_disk();
    logic [3:0] lines [4] = '{4'd14, 4'd15, 4'd10, 4'd11};
    for (int c = 0; c < 4; c++) begin
      wr(8'h4A, 8'(c));
      ide_pri_irq = 1;
      out_chk($sformatf("R3 primary code %0d", c), 16'(1) << lines[c], 24'h0);
      ide_pri_irq = 0;
      wr(8'h4A, 8'(c << 2));
      ide_sec_irq = 1;
      out_chk($sformatf("R3 secondary code %0d", c), 16'(1) << lines[c], 24'h0);
      ide_sec_irq = 0;
    end
    wr(8'h4A, 8'h00);
  endtask

  task automatic t_pci();
    logic [3:0] lines [4] = '{4'd5, 4'd7, 4'd9, 4'd11};
    wr(8'h55, 8'h50); wr(8'h56, 8'h97); wr(8'h57, 8'hB0);
    for (int i = 0; i < 4; i++) begin
      pci_int = 4'(1 << i);
      out_chk($sformatf("R4 input %0d", i), 16'(1) << lines[i], 24'h0);
    end
    wr(8'h55, 8'h00);
    pci_int = 4'b0001;
    out_chk("R4 zero turns off", 16'h0, 24'h0);
    pci_int = '0;
  endtask

  task automatic t_forbid();
    logic [3:0] bad [3] = '{4'd2, 4'd8, 4'd13};
    for (int i = 0; i < 3; i++) begin
      wr(8'h55, {bad[i], 4'h0});
      rd_chk($sformatf("R5 stored %0d", bad[i]), 8'h55, {bad[i], 4'h0});
      pci_int = 4'b0001;
      out_chk($sformatf("R5 quiet %0d", bad[i]), 16'h0, 24'h0);
      pci_int = '0;
    end
    wr(8'h58, 8'h80);
    wr(8'h55, 8'h80);
    pci_int = 4'b0001;
    out_chk("R5 quiet in apic mode", 16'h0, 24'h0);
    pci_int = '0;
    wr(8'h58, 8'h00); wr(8'h55, 8'h00);
  endtask

  task automatic t_dev();
    wr(8'h51, 8'h27); wr(8'h52, 8'h40); wr(8'h53, 8'h0C);
    par_irq = 1;  out_chk("R6 parallel line 2", 16'h0004, 24'h0); par_irq = 0;
    fdc_irq = 1;  out_chk("R6 floppy line 7", 16'h0080, 24'h0);   fdc_irq = 0;
    ser2_irq = 1; out_chk("R6 serial2 line 4", 16'h0010, 24'h0);  ser2_irq = 0;
    ser1_irq = 1; out_chk("R6 serial1 line 12", 16'h1000, 24'h0); ser1_irq = 0;
    wr(8'h51, 8'h00); wr(8'h52, 8'h00); wr(8'h53, 8'h00);
  endtask

  task automatic t_onb();
    logic [7:0] pins [5] = '{8'd4, 8'd4, 8'd3, 8'd3, 8'd1};
    wr(8'h60, 8'hA5);
    rd_chk("R7 line masked", 8'h60, 8'h05);
    onb_irq = 5'b00001;
    out_chk("R7 usb0 line 5", 16'h0020, 24'h0);
    onb_irq = '0;
    for (int k = 0; k < 5; k++) begin
      wr(8'(8'h68 + k), 8'hFF);
      rd_chk($sformatf("R7 pin %0d read-only", k), 8'(8'h68 + k), pins[k]);
    end
    wr(8'h60, 8'h00);
  endtask

  task automatic t_apic_onb();
    wr(8'h61, 8'h0E);
    wr(8'h58, 8'h02);
    onb_irq = 5'b00010;
    out_chk("R8 usb1 to apic 22", 16'h0, 24'h400000);
    wr(8'h64, 8'h0F); wr(8'h58, 8'h12);
    onb_irq = 5'b10000;
    out_chk("R8 power mgmt to apic 23", 16'h0, 24'h800000);
    wr(8'h58, 8'h00);
    onb_irq = 5'b00010;
    out_chk("R8 usb1 back to legacy 14", 16'h4000, 24'h0);
    onb_irq = '0;
    wr(8'h61, 8'h00); wr(8'h64, 8'h00);
  endtask

  task automatic t_apic_pci();
    wr(8'h55, 8'h30); wr(8'h56, 8'h54); wr(8'h57, 8'h60);
    wr(8'h58, 8'h80);
    pci_int = 4'b1010;
    out_chk("R9 inputs B D to apic 17 19", 16'h0, 24'h0A0000);
    pci_int = 4'b0101;
    out_chk("R9 inputs A C to apic 16 18", 16'h0, 24'h050000);
    wr(8'h58, 8'h00);
    out_chk("R9 back to legacy 3 5", 16'h0028, 24'h0);
    pci_int = '0;
    wr(8'h55, 8'h00); wr(8'h56, 8'h00); wr(8'h57, 8'h00);
  endtask

  task automatic t_share();
    wr(8'h55, 8'h50); wr(8'h51, 8'h50);
    pci_int = 4'b0001;
    out_chk("R10 pci alone", 16'h0020, 24'h0);
    pci_int = '0; par_irq = 1;
    out_chk("R10 parallel alone", 16'h0020, 24'h0);
    pci_int = 4'b0001;
    out_chk("R10 both", 16'h0020, 24'h0);
    idle_src();
    out_chk("R10 none", 16'h0, 24'h0);
    wr(8'h55, 8'h00); wr(8'h51, 8'h00);
  endtask

  task automatic t_unmapped();
    wr(8'h57, 8'h90);
    wr(8'h54, 8'hFF);
    wr(8'h59, 8'hFF);
    rd_chk("R11 read 0x54", 8'h54, 8'h00);
    rd_chk("R11 read 0x59", 8'h59, 8'h00);
    rd_chk("R11 neighbour kept", 8'h57, 8'h90);
    rd_chk("R11 steering kept", 8'h58, 8'h00);
    wr(8'h57, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    idle_src();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_disk();
    t_pci();
    t_forbid();
    t_dev();
    t_onb();
    t_apic_onb();
    t_apic_pci();
    t_share();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1_000_000;
    nchk++; nerr++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule